// File: doc/BRIEF.md
# FIFO Interrupt Status and Clear Unit

This block raises the interrupt for a serial controller from what happens at its transmit and receive FIFOs. It watches the FIFO fill levels against two programmable thresholds. It also watches the push and pop strobes against the full and empty flags. From these it builds a five-bit raw interrupt vector. That vector is gated by a mask register, and the OR of the gated bits drives a single registered interrupt line.

Two interrupt sources track the FIFO levels directly and drop again as soon as the level condition goes away. The three error sources are different: they latch when an illegal push or pop is attempted, and they stay set until software writes a clear register. The clear register has its own bit layout, which includes a bit that clears all three errors at once. Each threshold register keeps only the bits needed to index the FIFO depth, so software can find the depth by writing a value and reading it back.

Each sticky error flag is a two-state machine. FLAG_IDLE moves to FLAG_HELD on its error event. FLAG_HELD moves to FLAG_IDLE on a clear that arrives without a new event. In every other case the flag stays in its current state.

Top module: `fic_irq_unit`

## Requirements
- R1: raw_stat bit 0 is 1 exactly when tx_level is less than or equal to the stored transmit threshold; it follows the level in the same cycle and is not sticky.
- R2: raw_stat bit 4 is 1 exactly when rx_level is greater than or equal to the stored receive threshold; it follows the level in the same cycle and is not sticky.
- R3: a cycle with tx_push and tx_full both high sets raw_stat bit 1 from the next cycle on, and the bit holds until cleared; tx_push without tx_full does not set it.
- R4: a cycle with rx_push and rx_full both high sets raw_stat bit 3 from the next cycle on, and the bit holds until cleared.
- R5: a cycle with rx_pop and rx_empty both high sets raw_stat bit 2 from the next cycle on, and the bit holds until cleared.
- R6: a write of the clear port (clr_we high) acts on the next cycle. clr_wdata bit 1 clears raw bit 2, bit 2 clears raw bit 3 and bit 3 clears raw bit 1, and no bit clears any flag other than its own.
- R7: clr_wdata bit 0 clears all three sticky flags (raw bits 1, 2 and 3).
- R8: if a clear of a flag and a new error event for that flag fall in the same cycle, the flag is set afterwards.
- R9: masked_stat equals raw_stat ANDed with the 5-bit mask register, which uses the same bit positions and is loaded from mask_wdata when mask_we is high.
- R10: irq is the OR of masked_stat, registered: it shows the OR of the previous cycle.
- R11: a threshold write stores the low log2(DEPTH) bits of thr_wdata (4 bits by default), and the readback port returns those bits with every higher bit reading 0.
- R12: fifo_stat bits 0 to 4 are busy, tx_full, tx_empty, rx_empty and rx_full, in that order.
- R13: after reset the mask, both thresholds, the sticky flags and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tx_level | input | LVL_W | transmit FIFO fill level |
| rx_level | input | LVL_W | receive FIFO fill level |
| thr_tx_we | input | 1 | write strobe for the transmit threshold |
| thr_rx_we | input | 1 | write strobe for the receive threshold |
| thr_wdata | input | REG_W | threshold write data |
| thr_tx_rdata | output | REG_W | transmit threshold readback |
| thr_rx_rdata | output | REG_W | receive threshold readback |
| mask_we | input | 1 | mask register write strobe |
| mask_wdata | input | 5 | mask write data |
| clr_we | input | 1 | clear register write strobe |
| clr_wdata | input | 4 | clear register write data |
| tx_push | input | 1 | push attempt into the transmit FIFO |
| tx_full | input | 1 | transmit FIFO full |
| tx_empty | input | 1 | transmit FIFO empty |
| rx_push | input | 1 | push attempt into the receive FIFO |
| rx_pop | input | 1 | pop attempt from the receive FIFO |
| rx_full | input | 1 | receive FIFO full |
| rx_empty | input | 1 | receive FIFO empty |
| busy | input | 1 | serial engine busy |
| raw_stat | output | 5 | raw interrupt vector |
| masked_stat | output | 5 | masked interrupt vector |
| fifo_stat | output | 5 | FIFO status vector |
| irq | output | 1 | interrupt line |

## Verification
The bench sweeps every threshold against every fill level, including an empty FIFO and a full FIFO. A comparison that is off by one, or that uses the wrong direction, fails on the diagonal of that sweep. It writes threshold values with the upper bits set, which catches a register that keeps those bits instead of reading them back as zero. It tests each clear bit on its own and also lets a clear collide with a new error, so a swapped clear mapping, a leaky clear-all or a clear that wins over a new event would leave the wrong flag set. All 32 mask values are tried, and irq is checked one cycle after each change; a line that is driven combinationally, or that ignores the mask, shows up there.

// File: rtl/fic_pkg.sv
package fic_pkg;

    localparam int NUM_IRQ = 5;
    localparam int NUM_CLR = 4;
    localparam int NUM_ERR = 3;

    // raw interrupt vector positions
    localparam int IRQ_TX_LOW  = 0;
    localparam int IRQ_TX_OVF  = 1;
    localparam int IRQ_RX_UDF  = 2;
    localparam int IRQ_RX_OVF  = 3;
    localparam int IRQ_RX_HIGH = 4;

    // clear register positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;

    // sticky flag index: flag k drives raw bit k+1
    localparam int ERR_TX_OVF = 0;
    localparam int ERR_RX_UDF = 1;
    localparam int ERR_RX_OVF = 2;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/fic_thresh_reg.sv
module fic_thresh_reg #(
    parameter int REG_W = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [IDX_W-1:0] thr,
    output logic [REG_W-1:0] rdata
);

    localparam int PAD_W = REG_W - IDX_W;

    logic [IDX_W-1:0] thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (we) begin
            thr_q <= wdata[IDX_W-1:0];
        end
    end

    assign thr = thr_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, thr_q};
        end else begin : g_nopad
            assign rdata = thr_q;
        end
    endgenerate

endmodule

// File: rtl/fic_level_cmp.sv
module fic_level_cmp #(
    parameter int LVL_W = 5,
    parameter int IDX_W = 4,
    parameter bit ABOVE = 1'b0
) (
    input  logic [LVL_W-1:0] level,
    input  logic [IDX_W-1:0] thr,
    output logic             hit
);

    logic [LVL_W-1:0] thr_ext;

    assign thr_ext = LVL_W'(thr);

    generate
        if (ABOVE) begin : g_at_or_above
            assign hit = (level >= thr_ext);
        end else begin : g_at_or_below
            assign hit = (level <= thr_ext);
        end
    endgenerate

endmodule

// File: rtl/fic_sticky_flag.sv
module fic_sticky_flag
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_ev) state_d = FLAG_HELD;
            FLAG_HELD: if (clr_ev && !set_ev) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_HELD);
    end

endmodule

// File: rtl/fic_irq_unit.sv
module fic_irq_unit
    import fic_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int REG_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               thr_tx_we,
    input  logic               thr_rx_we,
    input  logic [REG_W-1:0]   thr_wdata,
    output logic [REG_W-1:0]   thr_tx_rdata,
    output logic [REG_W-1:0]   thr_rx_rdata,
    input  logic               mask_we,
    input  logic [NUM_IRQ-1:0] mask_wdata,
    input  logic               clr_we,
    input  logic [NUM_CLR-1:0] clr_wdata,
    input  logic               tx_push,
    input  logic               tx_full,
    input  logic               tx_empty,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               rx_full,
    input  logic               rx_empty,
    input  logic               busy,
    output logic [NUM_IRQ-1:0] raw_stat,
    output logic [NUM_IRQ-1:0] masked_stat,
    output logic [NUM_IRQ-1:0] fifo_stat,
    output logic               irq
);

    logic [IDX_W-1:0]   tx_thr;
    logic [IDX_W-1:0]   rx_thr;
    logic               tx_low;
    logic               rx_high;
    logic [NUM_ERR-1:0] err_set;
    logic [NUM_ERR-1:0] err_clr;
    logic [NUM_ERR-1:0] err_flag;
    logic [NUM_IRQ-1:0] mask_q;
    logic               irq_q;

    // threshold registers
    fic_thresh_reg #(.REG_W(REG_W), .IDX_W(IDX_W)) u_thr_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_tx_we),
        .wdata (thr_wdata),
        .thr   (tx_thr),
        .rdata (thr_tx_rdata)
    );

    fic_thresh_reg #(.REG_W(REG_W), .IDX_W(IDX_W)) u_thr_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_rx_we),
        .wdata (thr_wdata),
        .thr   (rx_thr),
        .rdata (thr_rx_rdata)
    );

    // level-type sources
    fic_level_cmp #(.LVL_W(LVL_W), .IDX_W(IDX_W), .ABOVE(1'b0)) u_cmp_tx (
        .level (tx_level),
        .thr   (tx_thr),
        .hit   (tx_low)
    );

    fic_level_cmp #(.LVL_W(LVL_W), .IDX_W(IDX_W), .ABOVE(1'b1)) u_cmp_rx (
        .level (rx_level),
        .thr   (rx_thr),
        .hit   (rx_high)
    );

    // error events and clear decode
    always_comb begin
        err_set             = '0;
        err_set[ERR_TX_OVF] = tx_push && tx_full;
        err_set[ERR_RX_UDF] = rx_pop  && rx_empty;
        err_set[ERR_RX_OVF] = rx_push && rx_full;

        err_clr             = '0;
        if (clr_we) begin
            err_clr[ERR_TX_OVF] = clr_wdata[CLR_ALL] | clr_wdata[CLR_TX_OVF];
            err_clr[ERR_RX_UDF] = clr_wdata[CLR_ALL] | clr_wdata[CLR_RX_UDF];
            err_clr[ERR_RX_OVF] = clr_wdata[CLR_ALL] | clr_wdata[CLR_RX_OVF];
        end
    end

    generate
        for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
            fic_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_ev (err_set[k]),
                .clr_ev (err_clr[k]),
                .flag   (err_flag[k])
            );
        end
    endgenerate

    // mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    // status assembly
    always_comb begin
        raw_stat              = '0;
        raw_stat[IRQ_TX_LOW]  = tx_low;
        raw_stat[IRQ_TX_OVF]  = err_flag[ERR_TX_OVF];
        raw_stat[IRQ_RX_UDF]  = err_flag[ERR_RX_UDF];
        raw_stat[IRQ_RX_OVF]  = err_flag[ERR_RX_OVF];
        raw_stat[IRQ_RX_HIGH] = rx_high;
        masked_stat           = raw_stat & mask_q;
        fifo_stat             = {rx_full, rx_empty, tx_empty, tx_full, busy};
    end

    // registered interrupt line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked_stat;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/fic_irq_unit_chk.sv
module fic_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_push,
    input logic       tx_full,
    input logic       rx_push,
    input logic       rx_full,
    input logic       rx_pop,
    input logic       rx_empty,
    input logic       clr_we,
    input logic [3:0] clr_wdata,
    input logic [4:0] raw_stat,
    input logic [4:0] masked_stat,
    input logic       irq
);

    a_r3_tx_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> raw_stat[1]);

    a_r4_rx_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> raw_stat[3]);

    a_r5_rx_udf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> raw_stat[2]);

    a_r6_tx_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[1] && !(clr_we && (clr_wdata[0] || clr_wdata[3]))) |=> raw_stat[1]);

    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_wdata[0] && !(tx_push && tx_full)) |=> !raw_stat[1]);

    a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|masked_stat)));

endmodule

bind fic_irq_unit fic_irq_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_push     (tx_push),
    .tx_full     (tx_full),
    .rx_push     (rx_push),
    .rx_full     (rx_full),
    .rx_pop      (rx_pop),
    .rx_empty    (rx_empty),
    .clr_we      (clr_we),
    .clr_wdata   (clr_wdata),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .irq         (irq)
);

// File: tb/fic_irq_unit_tb_top.sv
`timescale 1ns/1ps
module fic_irq_unit_tb_top;

    localparam int DEPTH = 16;
    localparam int REG_W = 8;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic             thr_tx_we = 1'b0;
    logic             thr_rx_we = 1'b0;
    logic [REG_W-1:0] thr_wdata = '0;
    logic [REG_W-1:0] thr_tx_rdata;
    logic [REG_W-1:0] thr_rx_rdata;
    logic             mask_we = 1'b0;
    logic [4:0]       mask_wdata = '0;
    logic             clr_we = 1'b0;
    logic [3:0]       clr_wdata = '0;
    logic             tx_push = 1'b0;
    logic             tx_full = 1'b0;
    logic             tx_empty = 1'b0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic             rx_full = 1'b0;
    logic             rx_empty = 1'b0;
    logic             busy = 1'b0;
    logic [4:0]       raw_stat;
    logic [4:0]       masked_stat;
    logic [4:0]       fifo_stat;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fic_irq_unit #(.DEPTH(DEPTH), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .thr_tx_we(thr_tx_we), .thr_rx_we(thr_rx_we), .thr_wdata(thr_wdata),
        .thr_tx_rdata(thr_tx_rdata), .thr_rx_rdata(thr_rx_rdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
        .busy(busy), .raw_stat(raw_stat), .masked_stat(masked_stat),
        .fifo_stat(fifo_stat), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic raise_errors();
        tx_push = 1; tx_full = 1; rx_push = 1; rx_full = 1; rx_pop = 1; rx_empty = 1;
        tick();
        tx_push = 0; tx_full = 0; rx_push = 0; rx_full = 0; rx_pop = 0; rx_empty = 0;
    endtask

    task automatic write_clear(input logic [3:0] d);
        clr_we = 1; clr_wdata = d;
        tick();
        clr_we = 0; clr_wdata = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R13 reset state: levels 0 against thresholds 0 hit both level sources
        check("R13 raw", int'(raw_stat), 5'b10001);
        check("R13 masked", int'(masked_stat), 0);
        check("R13 irq", int'(irq), 0);
        check("R13 thr_tx", int'(thr_tx_rdata), 0);
        check("R13 thr_rx", int'(thr_rx_rdata), 0);
        rst_n = 1;
        tick();
        check("R13 irq after release", int'(irq), 0);

        // R11, R1, R2: threshold sweep with junk in the upper bits
        for (int t = 0; t < DEPTH; t++) begin
            thr_wdata = REG_W'(((t * 5 + 3) % 16) << 4 | t);
            thr_tx_we = 1; thr_rx_we = 1;
            tick();
            thr_tx_we = 0; thr_rx_we = 0;
            check("R11 tx readback", int'(thr_tx_rdata), t);
            check("R11 rx readback", int'(thr_rx_rdata), t);
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = LVL_W'(l);
                rx_level = LVL_W'(DEPTH - l);
                #1;
                check("R1 tx at or below", int'(raw_stat[0]), (l <= t) ? 1 : 0);
                check("R2 rx at or above", int'(raw_stat[4]), ((DEPTH - l) >= t) ? 1 : 0);
            end
            tick();
        end

        // park levels so raw[0]=0 and raw[4]=0 (tx thr 15, rx thr 15)
        tx_level = LVL_W'(DEPTH); rx_level = '0;
        tick();
        check("R1 full tx fifo", int'(raw_stat[0]), 0);

        // R3: push without full does not set
        tx_push = 1; tick(); tx_push = 0; tick();
        check("R3 push not full", int'(raw_stat[1]), 0);
        tx_full = 1; tick(); tx_full = 0; tick();
        check("R3 full no push", int'(raw_stat[1]), 0);
        tx_push = 1; tx_full = 1; tick(); tx_push = 0; tx_full = 0;
        check("R3 tx overflow set", int'(raw_stat[1]), 1);
        repeat (4) tick();
        check("R3 tx overflow sticky", int'(raw_stat[1]), 1);

        // R4
        rx_push = 1; rx_full = 1; tick(); rx_push = 0; rx_full = 0;
        check("R4 rx overflow set", int'(raw_stat[3]), 1);
        // R5
        rx_pop = 1; tick(); rx_pop = 0;
        check("R5 pop not empty", int'(raw_stat[2]), 0);
        rx_pop = 1; rx_empty = 1; tick(); rx_pop = 0; rx_empty = 0;
        check("R5 rx underflow set", int'(raw_stat[2]), 1);
        repeat (3) tick();
        check("R5 sticky", int'(raw_stat[3:1]), 3'b111);

        // R6: each clear bit hits only its own flag
        write_clear(4'b0010);
        check("R6 clear rx underflow", int'(raw_stat[3:1]), 3'b101);
        write_clear(4'b0100);
        check("R6 clear rx overflow", int'(raw_stat[3:1]), 3'b001);
        write_clear(4'b1000);
        check("R6 clear tx overflow", int'(raw_stat[3:1]), 3'b000);
        raise_errors();
        write_clear(4'b1000);
        check("R6 tx clear only", int'(raw_stat[3:1]), 3'b110);
        clr_wdata = 4'b1111; tick(); clr_wdata = '0;
        check("R6 no write strobe", int'(raw_stat[3:1]), 3'b110);

        // R7 clear all
        raise_errors();
        write_clear(4'b0001);
        check("R7 clear all", int'(raw_stat[3:1]), 3'b000);

        // R8: set wins over simultaneous clear
        raise_errors();
        clr_we = 1; clr_wdata = 4'b0001; tx_push = 1; tx_full = 1;
        tick();
        clr_we = 0; clr_wdata = '0; tx_push = 0; tx_full = 0;
        check("R8 set wins held flag", int'(raw_stat[3:1]), 3'b001);
        write_clear(4'b0001);
        clr_we = 1; clr_wdata = 4'b0100; rx_push = 1; rx_full = 1;
        tick();
        clr_we = 0; clr_wdata = '0; rx_push = 0; rx_full = 0;
        check("R8 set wins idle flag", int'(raw_stat[3:1]), 3'b100);

        // R9, R10: mask sweep with all raw bits set
        raise_errors();
        tx_level = '0; rx_level = LVL_W'(DEPTH);
        tick();
        check("R9 all raw", int'(raw_stat), 5'h1F);
        for (int m = 0; m < 32; m++) begin
            mask_we = 1; mask_wdata = 5'(m);
            tick();
            mask_we = 0;
            check("R9 masked", int'(masked_stat), m);
            tick();
            check("R10 irq", int'(irq), (m != 0) ? 1 : 0);
        end
        // R10 one-cycle lag on a falling source
        mask_we = 1; mask_wdata = 5'b00001; tick(); mask_we = 0; tick();
        check("R10 irq before", int'(irq), 1);
        tx_level = LVL_W'(DEPTH);
        #1;
        check("R9 masked drops", int'(masked_stat), 0);
        check("R10 irq lags", int'(irq), 1);
        tick();
        check("R10 irq falls", int'(irq), 0);

        // R12 status sweep
        for (int s = 0; s < 32; s++) begin
            busy = s[0]; tx_full = s[1]; tx_empty = s[2]; rx_empty = s[3]; rx_full = s[4];
            #1;
            check("R12 status", int'(fifo_stat), s);
            tick();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule